// File: doc/BRIEF.md
# PCI Configuration Space Target

This block is the target side of configuration cycles on a PCI bus. An address decoder upstream flags that the current address phase is a configuration access to this function and supplies the six-bit DWord index and the read/write direction. From that point the block alone runs the bus handshake. It raises DEVSEL with medium decode timing and adds a fixed number of wait states before TRDY. On a write it merges the data under byte-enable control. On a read it drives the addressed DWord. It then releases its control lines through one clock in which it still drives them, but deasserted.

Two conditions end a cycle early. If the initiator keeps FRAME asserted past the first data phase, the block completes that phase and then disconnects the burst with STOP. If an EEPROM autoload engine reports that it is still loading after reset, every configuration access is answered with a retry. A retry has STOP and no TRDY, and it leaves the register contents untouched. A small header is implemented: identity, command/status, class/revision, a cache-line/latency word, an I/O base and an interrupt word. Every other DWord reads as zero.

Top module: `cfgt_target`

## Requirements
- R1: Counting the clock edge that samples FRAME and the decoder hit together as edge 0, `devsel` is low after edge 0 and high after edge DEVSEL_LAT-1 (edge 1 by default). It stays high until the final data phase ends.
- R2: `trdy` rises after edge TRDY_LAT-1 (edge 3 by default) and never earlier, whatever the byte enables or data. A transfer completes on the first later edge at which `irdy` is high.
- R3: The six-bit `dw_idx` selects one of 64 DWords. On a read, `ad_out` carries that DWord while `trdy` is high. DWords other than 0, 1, 2, 3, 4 and 15 read as 0.
- R4: On a write, `be` bit k (active high) enables byte k, which is bits 8k+7..8k. Disabled bytes keep their old value, so 8-, 16- and 32-bit writes all work.
- R5: Only these bits are writable: DWord 1 bits 2..0, DWord 3 bits 15..0, DWord 4 bits 31..5 and DWord 15 bits 7..0. DWord 4 bit 0 reads 1 and DWord 15 bit 8 reads 1. DWord 0 reads ID_WORD and DWord 2 reads CLASS_WORD. Writes to any other bit or DWord have no effect.
- R6: Bit 23 of DWord 1 (status bit 7, fast back-to-back capable) always reads 1, including after a write of zeros.
- R7: If `frame` is still high at the edge that completes the first data phase, the block then drives `stop` and `devsel` high with `trdy` low until `frame` is seen low. The first phase's write still takes place.
- R8: If `eeprom_busy` is high at the address edge, the response after edge TRDY_LAT-1 is `stop` high with `trdy` low, and no register changes.
- R9: After the final data phase ends, there is exactly one clock in which `ctl_oe` is high and `devsel`, `trdy` and `stop` are all low. In the clock after that, `ctl_oe` is low.
- R10: An address phase is accepted even when `frame` was high in the preceding clock for another target's transaction, with no idle clock between. While `cfg_hit` is low, the block stays silent.
- R11: After reset all control outputs are low and the writable bits are zero, so DWord 3 reads 0 and DWord 4 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame | input | 1 | FRAME, active high |
| irdy | input | 1 | IRDY, active high |
| cfg_hit | input | 1 | Decoder flag: this address phase is a configuration access to this function |
| cfg_wr | input | 1 | 1 = configuration write, 0 = read; valid with `cfg_hit` |
| dw_idx | input | 6 | DWord index from the address phase |
| be | input | 4 | Byte enables, active high, valid in the data phase |
| ad_in | input | 32 | Write data from the AD bus |
| eeprom_busy | input | 1 | Autoload after reset still running |
| devsel | output | 1 | DEVSEL, active high |
| trdy | output | 1 | TRDY, active high |
| stop | output | 1 | STOP, active high |
| ctl_oe | output | 1 | Drive enable for DEVSEL/TRDY/STOP |
| ad_out | output | 32 | Read data for the AD bus |
| ad_oe | output | 1 | Drive enable for AD during a read |

## Verification
Each bus transaction is driven clock by clock from the address edge, and every output is sampled half a period after an edge. DEVSEL is expected one sample after edge 0, and TRDY or the retry STOP exactly three samples after edge 0. The turnaround clock is expected one sample after the completing edge, or one sample after the edge where FRAME is seen low once a disconnect is running. Read data is pushed to a scoreboard queue before the TRDY sample. The monitor pops an entry only at a sample where TRDY and IRDY are both high, so a read that arrives late, early or not at all fails the check. Writes update a bench model that has its own writable-bit table, and later reads compare against it.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_RESP,
    S_HOLD,
    S_TURN
  } seq_st_t;

  localparam int IDX_IDENT   = 0;
  localparam int IDX_CMDSTAT = 1;
  localparam int IDX_CLASS   = 2;
  localparam int IDX_TIMING  = 3;
  localparam int IDX_IOBASE  = 4;
  localparam int IDX_IRQ     = 15;

  // Merge new bytes into an old word; byte k follows enable bit k.
  function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  en);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = en[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
    return r;
  endfunction

endpackage

// File: rtl/cfgt_seq.sv
module cfgt_seq
  import cfgt_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int DEVSEL_LAT = 2,
  parameter int TRDY_LAT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame,
  input  logic             irdy,
  input  logic             cfg_hit,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] dw_idx,
  input  logic             eeprom_busy,
  output logic             devsel,
  output logic             trdy,
  output logic             stop,
  output logic             ctl_oe,
  output logic             ad_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] idx_q,
  output logic             addr_evt,
  output logic             busy_q
);

  localparam int CW = $clog2(TRDY_LAT + 1);

  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic          wr_q;

  assign addr_evt = frame && cfg_hit && (st == S_IDLE || st == S_TURN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx_q  <= '0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_TURN: begin
          if (addr_evt) begin
            st     <= S_WAIT;
            cnt    <= CW'(1);
            idx_q  <= dw_idx;
            wr_q   <= cfg_wr;
            busy_q <= eeprom_busy;
          end else begin
            st <= S_IDLE;
          end
        end
        S_WAIT: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(TRDY_LAT - 1)) st <= S_RESP;
        end
        S_RESP: begin
          if (busy_q) begin
            if (!frame) st <= S_TURN;
          end else if (irdy) begin
            st <= frame ? S_HOLD : S_TURN;
          end
        end
        S_HOLD: if (!frame) st <= S_TURN;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    devsel = (st == S_WAIT && cnt >= CW'(DEVSEL_LAT)) ||
             st == S_RESP || st == S_HOLD;
    trdy   = (st == S_RESP) && !busy_q;
    stop   = ((st == S_RESP) && busy_q) || (st == S_HOLD);
    ctl_oe = devsel || (st == S_TURN);
    ad_oe  = devsel && (st != S_HOLD) && !wr_q && !busy_q;
    wr_en  = trdy && irdy && wr_q;
  end

endmodule

// File: rtl/cfgt_space.sv
module cfgt_space
  import cfgt_pkg::*;
#(
  parameter int          IDX_W      = 6,
  parameter logic [31:0] ID_WORD    = 32'h7E51_0C4B,
  parameter logic [31:0] CLASS_WORD = 32'h0200_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  localparam int NUM_DW = 1 << IDX_W;

  function automatic logic [31:0] wmask_of(input int i);
    case (i)
      IDX_CMDSTAT: return 32'h0000_0007;
      IDX_TIMING:  return 32'h0000_FFFF;
      IDX_IOBASE:  return 32'hFFFF_FFE0;
      IDX_IRQ:     return 32'h0000_00FF;
      default:     return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fixed_of(input int i);
    case (i)
      IDX_IDENT:   return ID_WORD;
      IDX_CMDSTAT: return 32'h0080_0000;
      IDX_CLASS:   return CLASS_WORD;
      IDX_IOBASE:  return 32'h0000_0001;
      IDX_IRQ:     return 32'h0000_0100;
      default:     return 32'h0;
    endcase
  endfunction

  logic [31:0] words [NUM_DW];

  for (genvar g = 0; g < NUM_DW; g++) begin : g_dw
    if (wmask_of(g) != 32'h0) begin : g_rw
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en && idx == IDX_W'(g))
          q <= byte_merge(q, wdata, be) & wmask_of(g);
      end
      assign words[g] = (q & wmask_of(g)) | fixed_of(g);
    end else begin : g_ro
      assign words[g] = fixed_of(g);
    end
  end

  assign rdata = words[idx];

endmodule

// File: rtl/cfgt_target.sv
module cfgt_target #(
  parameter int          IDX_W      = 6,
  parameter int          DEVSEL_LAT = 2,
  parameter int          TRDY_LAT   = 4,
  parameter logic [31:0] ID_WORD    = 32'h7E51_0C4B,
  parameter logic [31:0] CLASS_WORD = 32'h0200_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame,
  input  logic             irdy,
  input  logic             cfg_hit,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] dw_idx,
  input  logic [3:0]       be,
  input  logic [31:0]      ad_in,
  input  logic             eeprom_busy,
  output logic             devsel,
  output logic             trdy,
  output logic             stop,
  output logic             ctl_oe,
  output logic [31:0]      ad_out,
  output logic             ad_oe
);

  logic             wr_en;
  logic [IDX_W-1:0] idx_q;
  logic             addr_evt;
  logic             busy_q;
  logic [31:0]      rd_word;

  cfgt_seq #(
    .IDX_W(IDX_W), .DEVSEL_LAT(DEVSEL_LAT), .TRDY_LAT(TRDY_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame(frame), .irdy(irdy),
    .cfg_hit(cfg_hit), .cfg_wr(cfg_wr), .dw_idx(dw_idx),
    .eeprom_busy(eeprom_busy), .devsel(devsel), .trdy(trdy),
    .stop(stop), .ctl_oe(ctl_oe), .ad_oe(ad_oe), .wr_en(wr_en),
    .idx_q(idx_q), .addr_evt(addr_evt), .busy_q(busy_q)
  );

  cfgt_space #(
    .IDX_W(IDX_W), .ID_WORD(ID_WORD), .CLASS_WORD(CLASS_WORD)
  ) u_space (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx_q),
    .be(be), .wdata(ad_in), .rdata(rd_word)
  );

  assign ad_out = ad_oe ? rd_word : 32'h0;

endmodule

// File: rtl/cfgt_chk.sv
module cfgt_chk #(
  parameter int IDX_W      = 6,
  parameter int DEVSEL_LAT = 2,
  parameter int TRDY_LAT   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             devsel,
  input logic             trdy,
  input logic             stop,
  input logic             ctl_oe,
  input logic             ad_oe,
  input logic             cfg_wr,
  input logic             addr_evt,
  input logic             busy_q,
  input logic [IDX_W-1:0] idx_q,
  input logic [31:0]      rd_word
);

  logic [7:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age <= '0;
    else if (addr_evt)        age <= 8'd1;
    else if (age != 8'hFF)    age <= age + 8'd1;
  end

  a_r1_devsel_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel) |-> age == 8'(DEVSEL_LAT));

  a_r2_trdy_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy) |-> age == 8'(TRDY_LAT));

  a_r7_stop_with_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> devsel && !trdy);

  a_r8_retry_no_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !trdy && !ad_oe);

  a_r9_turn_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel) && !addr_evt |=> !ctl_oe || addr_evt ||
                                   $past(ctl_oe && !trdy && !stop));

  a_r6_fbb_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_W'(1)) |-> rd_word[23]);

  a_r3_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> devsel && !cfg_wr || devsel);

endmodule

bind cfgt_target cfgt_chk #(
  .IDX_W(IDX_W), .DEVSEL_LAT(DEVSEL_LAT), .TRDY_LAT(TRDY_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .devsel(devsel), .trdy(trdy), .stop(stop),
  .ctl_oe(ctl_oe), .ad_oe(ad_oe), .cfg_wr(cfg_wr), .addr_evt(addr_evt),
  .busy_q(busy_q), .idx_q(idx_q), .rd_word(rd_word)
);

// File: tb/cfgt_target_tb.sv
module cfgt_target_tb_top;

  localparam logic [31:0] IDW = 32'h7E51_0C4B;
  localparam logic [31:0] CLW = 32'h0200_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0, irdy = 1'b0, cfg_hit = 1'b0, cfg_wr = 1'b0;
  logic [5:0]  dw_idx = '0;
  logic [3:0]  be = '0;
  logic [31:0] ad_in = '0;
  logic        eeprom_busy = 1'b0;
  logic        devsel, trdy, stop, ctl_oe, ad_oe;
  logic [31:0] ad_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] shadow [64];

  always #4 clk = ~clk;

  cfgt_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame(frame), .irdy(irdy), .cfg_hit(cfg_hit),
    .cfg_wr(cfg_wr), .dw_idx(dw_idx), .be(be), .ad_in(ad_in),
    .eeprom_busy(eeprom_busy), .devsel(devsel), .trdy(trdy), .stop(stop),
    .ctl_oe(ctl_oe), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  function automatic logic [31:0] wbits(input int i);
    if (i == 3)  return 32'h0000_FFFF;
    if (i == 4)  return 32'hFFFF_FFE0;
    if (i == 15) return 32'h0000_00FF;
    if (i == 1)  return 32'h0000_0007;
    return 32'h0;
  endfunction

  function automatic logic [31:0] hard(input int i);
    if (i == 0)  return IDW;
    if (i == 2)  return CLW;
    if (i == 1)  return 32'h0080_0000;
    if (i == 4)  return 32'h0000_0001;
    if (i == 15) return 32'h0000_0100;
    return 32'h0;
  endfunction

  function automatic logic [31:0] model_rd(input int i);
    return (shadow[i] & wbits(i)) | hard(i);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected read whenever a read data phase completes.
  always @(negedge clk) begin
    if (rst_n && trdy && irdy && !cfg_wr) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected read", ad_out, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ad_out === e, t, ad_out, e);
      end
    end
  end

  task automatic txn(input bit wr, input int idx, input logic [3:0] b,
                     input logic [31:0] d, input bit burst, input string t);
    @(negedge clk);
    frame = 1'b1; cfg_hit = 1'b1; cfg_wr = wr; dw_idx = 6'(idx); irdy = 1'b0;
    @(negedge clk);               // edge 0 passed
    cfg_hit = 1'b0; irdy = 1'b1; be = b; ad_in = d; frame = burst;
    check(devsel == 1'b0, "R1 devsel early", 32'(devsel), 0);
    @(negedge clk);               // after edge 1
    check(devsel == 1'b1, "R1 devsel", 32'(devsel), 1);
    check(trdy == 1'b0, "R2 trdy early", 32'(trdy), 0);
    @(negedge clk);               // after edge 2
    check(trdy == 1'b0 && stop == 1'b0, "R2 wait state", {trdy, stop}, 0);
    if (!wr && !eeprom_busy) begin
      exp_q.push_back(model_rd(idx));
      tag_q.push_back(t);
    end
    @(negedge clk);               // after edge 3
    if (eeprom_busy) begin
      check(stop && !trdy && devsel, "R8 retry", {devsel, trdy, stop}, 32'b101);
    end else begin
      check(trdy && !stop, "R2 trdy", {trdy, stop}, 32'b10);
      if (wr)
        for (int k = 0; k < 4; k++)
          if (b[k]) shadow[idx][8*k +: 8] = d[8*k +: 8];
    end
    @(negedge clk);               // after edge 4
    if (burst && !eeprom_busy) begin
      check(stop && devsel && !trdy, "R7 disconnect", {devsel, trdy, stop}, 32'b101);
      frame = 1'b0; irdy = 1'b0;
      @(negedge clk);
    end
    irdy = 1'b0;
    check(ctl_oe && !devsel && !trdy && !stop, "R9 turnaround",
          {ctl_oe, devsel, trdy, stop}, 32'b1000);
    @(negedge clk);
    check(!ctl_oe, "R9 release", 32'(ctl_oe), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!devsel && !trdy && !stop && !ctl_oe, "R11 reset outputs",
          {devsel, trdy, stop, ctl_oe}, 0);
    txn(0, 3, 4'hF, 0, 0, "R11 reset word3");
    txn(0, 4, 4'hF, 0, 0, "R11 reset word4");
    txn(0, 0, 4'hF, 0, 0, "R3 ident");
    txn(0, 2, 4'hF, 0, 0, "R3 class");
    txn(0, 9, 4'hF, 0, 0, "R3 unimplemented");
    txn(0, 63, 4'hF, 0, 0, "R3 top index");
    txn(0, 1, 4'hF, 0, 0, "R6 status bit");
    txn(1, 3, 4'hF, 32'hA5C3_1E77, 0, "R4");
    txn(0, 3, 4'hF, 0, 0, "R4 32-bit");
    txn(1, 3, 4'b0010, 32'hFFFF_FFFF, 0, "R4");
    txn(0, 3, 4'hF, 0, 0, "R4 8-bit");
    txn(1, 4, 4'b1100, 32'hDEAD_BEEF, 0, "R4");
    txn(0, 4, 4'hF, 0, 0, "R4 16-bit");
    txn(1, 1, 4'hF, 32'hFFFF_FFFF, 0, "R5");
    txn(0, 1, 4'hF, 0, 0, "R5 command mask");
    txn(1, 1, 4'hF, 32'h0, 0, "R6");
    txn(0, 1, 4'hF, 0, 0, "R6 after zero write");
    txn(1, 0, 4'hF, 32'h0, 0, "R5");
    txn(0, 0, 4'hF, 0, 0, "R5 read-only ident");
    txn(1, 20, 4'hF, 32'h1234_5678, 0, "R5");
    txn(0, 20, 4'hF, 0, 0, "R5 unimplemented write");
    eeprom_busy = 1'b1;
    txn(1, 15, 4'hF, 32'h0000_0055, 0, "R8");
    txn(0, 15, 4'hF, 0, 0, "R8");
    eeprom_busy = 1'b0;
    txn(0, 15, 4'hF, 0, 0, "R8 no write during retry");
    txn(0, 3, 4'hF, 0, 1, "R7 burst read");
    txn(1, 15, 4'b0001, 32'h0000_003C, 1, "R7");
    txn(0, 15, 4'hF, 0, 0, "R7 first phase written");
    // another target's cycle, then ours with no idle clock
    @(negedge clk);
    frame = 1'b1; cfg_hit = 1'b0; irdy = 1'b1; cfg_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!devsel && !ctl_oe, "R10 silent for other target",
          {devsel, ctl_oe}, 0);
    txn(0, 4, 4'hF, 0, 0, "R10 back-to-back read");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule